// File: doc/BRIEF.md
# Program Address Sequencer with Three-Level Return Stack

This block keeps the 12-bit address of the instruction being fetched and a small hardware return stack for subroutine calls. Each clock it accepts one decoded control request from the instruction decoder (advance, far jump, call, return, conditional jump or in-page jump) together with the address fields taken from the instruction. It then produces the next fetch address. The return stack has no pointer that software can see. It is a fixed push-down array of three entries that shifts on every call and every return.

A conditional jump carries a 4-bit condition code. The three lower bits select tests on the accumulator-zero flag, the carry flag and the external test input. The selected tests are ORed together, and the top bit of the code inverts the result. On a return, the block hands an immediate nibble to the accumulator path. That nibble and a one-cycle load strobe appear in the same cycle as the restored address.

Top module: `prog_addr_unit`

## Requirements
- R1: While rst_n is low and after its release, fetch_addr is 0, ret_load is 0 and every return stack entry is 0. A return issued before any call therefore yields address 0.
- R2: The request code br_kind is 0 for none, 1 for far jump, 2 for call, 3 for return, 4 for conditional jump and 5 for in-page jump. Codes 6 and 7 act as none. With no request, adv_en=1 adds 1 to fetch_addr modulo 4096, so 0xFFF becomes 0x000. With adv_en=0 the address holds.
- R3: A far jump (code 1) loads fetch_addr with {tgt_hi, tgt_lo}.
- R4: A call (code 2) loads fetch_addr with {tgt_hi, tgt_lo} and pushes the old fetch_addr+2 (modulo 4096) as the newest stack entry.
- R5: A return (code 3) loads fetch_addr from the newest stack entry and pops the stack. In the cycle that the new address appears, ret_load is 1 and ret_nib equals the imm_nib given with the request. In every other cycle ret_load is 0.
- R6: A conditional jump (code 4) is taken when the following expression is 1: ((cond[2] & acc_zero) | (cond[1] & carry) | (cond[0] & ~test_in)) XOR cond[3]. When taken, fetch_addr becomes {old fetch_addr[11:8], tgt_lo}. Otherwise it becomes old fetch_addr+2. With cond=0000 the jump is never taken, and with cond=1000 it is always taken.
- R7: An in-page jump (code 5) loads fetch_addr with {old fetch_addr[11:8], tgt_lo}.
- R8: Any request with code 1 to 5 takes priority over adv_en in the same cycle.
- R9: A call made while three entries are already saved discards the oldest entry. The following returns give the three newest return addresses, newest first.
- R10: A pop shifts the entries toward the newest position and keeps the oldest position unchanged. A return with no saved entries left therefore yields the value held in the oldest position, and it does so again on every further return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_en | input | 1 | Sequential advance by one |
| br_kind | input | 3 | Control request code (see R2) |
| tgt_hi | input | 4 | Upper address nibble for far jump and call |
| tgt_lo | input | 8 | Low address byte for all jump kinds |
| cond | input | 4 | Condition code for conditional jump |
| acc_zero | input | 1 | Accumulator equals zero |
| carry | input | 1 | Carry flag |
| test_in | input | 1 | External test input |
| imm_nib | input | 4 | Immediate nibble delivered on return |
| fetch_addr | output | 12 | Current fetch address |
| ret_load | output | 1 | Strobe: load ret_nib into the accumulator |
| ret_nib | output | 4 | Immediate nibble from the last return |

## Verification
Two functions can fall in the same cycle. The first is a branch request that arrives together with the sequential advance strobe; the bench drives both at once in directed steps and during random traffic, and counts a result as correct only if the address follows the branch rule and never old+1. The second is a call arriving while the stack is already full, where the push has to discard the oldest entry in the same shift that stores the new one; the bench makes four nested calls and then five returns, and compares every returned address with a queue model. That model also checks the return strobe and the nibble in the same cycle as the restored address.

// File: rtl/pas_pkg.sv
package pas_pkg;
  localparam int ADDR_W = 12;
  localparam int PAGE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    REQ_NONE = 3'd0,
    REQ_FAR  = 3'd1,
    REQ_CALL = 3'd2,
    REQ_RET  = 3'd3,
    REQ_COND = 3'd4,
    REQ_NEAR = 3'd5
  } req_kind_e;

  // Selected tests ORed, then bit 3 inverts.
  function automatic logic cond_met(input logic [3:0] c, input logic az,
                                    input logic cy, input logic tst);
    logic any;
    any = (c[2] & az) | (c[1] & cy) | (c[0] & ~tst);
    return any ^ c[3];
  endfunction

  // Address plus a small step, wrapping at the address width.
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] n);
    return a + ADDR_W'(n);
  endfunction

  // Keep the current page, replace the in-page part.
  function automatic logic [ADDR_W-1:0] in_page(input logic [ADDR_W-1:0] a,
                                                input logic [PAGE_W-1:0] lo);
    return {a[ADDR_W-1:PAGE_W], lo};
  endfunction
endpackage

// File: rtl/pas_cond_eval.sv
module pas_cond_eval (
  input  logic [3:0] cond,
  input  logic       acc_zero,
  input  logic       carry,
  input  logic       test_in,
  output logic       taken
);
  import pas_pkg::*;
  always_comb taken = cond_met(cond, acc_zero, carry, test_in);
endmodule

// File: rtl/pas_ret_stack.sv
module pas_ret_stack #(
  parameter int DEPTH = 3,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top
);
  logic [W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] from_above;
    logic [W-1:0] from_below;
    if (i == 0) begin : g_first
      assign from_above = push_val;
    end else begin : g_rest
      assign from_above = ent[i-1];
    end
    if (i == DEPTH-1) begin : g_last
      assign from_below = ent[i];
    end else begin : g_mid
      assign from_below = ent[i+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ent[i] <= '0;
      else if (push) ent[i] <= from_above;
      else if (pop)  ent[i] <= from_below;
    end
  end

  assign top = ent[0];
endmodule

// File: rtl/pas_addr_reg.sv
module pas_addr_reg #(
  parameter int AW = 12,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    kind,
  input  logic          adv_en,
  input  logic [AW-PW-1:0] tgt_hi,
  input  logic [PW-1:0] tgt_lo,
  input  logic          cond_ok,
  input  logic [AW-1:0] pop_val,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] ret_addr
);
  import pas_pkg::*;
  logic [AW-1:0] nxt;

  assign ret_addr = addr_step(addr, 2'd2);

  always_comb begin
    case (kind)
      REQ_FAR, REQ_CALL: nxt = {tgt_hi, tgt_lo};
      REQ_RET:           nxt = pop_val;
      REQ_COND:          nxt = cond_ok ? in_page(addr, tgt_lo) : addr_step(addr, 2'd2);
      REQ_NEAR:          nxt = in_page(addr, tgt_lo);
      default:           nxt = adv_en ? addr_step(addr, 2'd1) : addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= nxt;
  end
endmodule

// File: rtl/prog_addr_unit.sv
module prog_addr_unit #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 8,
  parameter int NIB_W  = 4,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic [2:0]        br_kind,
  input  logic [ADDR_W-PAGE_W-1:0] tgt_hi,
  input  logic [PAGE_W-1:0] tgt_lo,
  input  logic [3:0]        cond,
  input  logic              acc_zero,
  input  logic              carry,
  input  logic              test_in,
  input  logic [NIB_W-1:0]  imm_nib,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              ret_load,
  output logic [NIB_W-1:0]  ret_nib
);
  import pas_pkg::*;

  // Named internal events for the checker.
  logic              ev_push;
  logic              ev_pop;
  logic              ev_cond_ok;
  logic [ADDR_W-1:0] stk_top;
  logic [ADDR_W-1:0] ret_addr;

  assign ev_push = (br_kind == REQ_CALL);
  assign ev_pop  = (br_kind == REQ_RET);

  pas_cond_eval u_cond (
    .cond(cond), .acc_zero(acc_zero), .carry(carry), .test_in(test_in),
    .taken(ev_cond_ok)
  );

  pas_ret_stack #(.DEPTH(DEPTH), .W(ADDR_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .pop(ev_pop),
    .push_val(ret_addr), .top(stk_top)
  );

  pas_addr_reg #(.AW(ADDR_W), .PW(PAGE_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .kind(br_kind), .adv_en(adv_en),
    .tgt_hi(tgt_hi), .tgt_lo(tgt_lo), .cond_ok(ev_cond_ok),
    .pop_val(stk_top), .addr(fetch_addr), .ret_addr(ret_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_load <= 1'b0;
      ret_nib  <= '0;
    end else begin
      ret_load <= ev_pop;
      if (ev_pop) ret_nib <= imm_nib;
    end
  end
endmodule

// File: rtl/prog_addr_unit_chk.sv
module prog_addr_unit_chk #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 8,
  parameter int NIB_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv_en,
  input logic [2:0]        br_kind,
  input logic [ADDR_W-PAGE_W-1:0] tgt_hi,
  input logic [PAGE_W-1:0] tgt_lo,
  input logic [NIB_W-1:0]  imm_nib,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              ret_load,
  input logic [NIB_W-1:0]  ret_nib,
  input logic [ADDR_W-1:0] stk_top
);
  logic idle_req;
  assign idle_req = (br_kind == 3'd0) || (br_kind > 3'd5);

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |-> fetch_addr == '0 && !ret_load); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req && adv_en |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req && !adv_en |=> $stable(fetch_addr)); // R2
  AST_FAR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    br_kind == 3'd1 |=> fetch_addr == {$past(tgt_hi), $past(tgt_lo)}); // R3
  AST_CALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    br_kind == 3'd2 |=> stk_top == ADDR_W'($past(fetch_addr) + 2)); // R4
  AST_RET_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    br_kind == 3'd3 |=> ret_load && ret_nib == $past(imm_nib)); // R5
  AST_RET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    br_kind != 3'd3 |=> !ret_load); // R5
  AST_NEAR_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    br_kind == 3'd5 |=> fetch_addr == {$past(fetch_addr[ADDR_W-1:PAGE_W]), $past(tgt_lo)}); // R7
endmodule

bind prog_addr_unit prog_addr_unit_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .br_kind(br_kind), .tgt_hi(tgt_hi),
  .tgt_lo(tgt_lo), .imm_nib(imm_nib), .fetch_addr(fetch_addr), .ret_load(ret_load),
  .ret_nib(ret_nib), .stk_top(stk_top)
);

// File: tb/test_prog_addr_unit.sv
module test_prog_addr_unit;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       adv_en = 0;
  logic [2:0] br_kind = 0;
  logic [3:0] tgt_hi = 0;
  logic [7:0] tgt_lo = 0;
  logic [3:0] cond = 0;
  logic       acc_zero = 0, carry = 0, test_in = 0;
  logic [3:0] imm_nib = 0;
  logic [11:0] fetch_addr;
  logic        ret_load;
  logic [3:0]  ret_nib;

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";

  // Reference model
  int m_pc = 0;
  int m_stk[$] = '{0, 0, 0};
  bit m_rl = 0;
  int m_rn = 0;

  always #4 clk = ~clk;

  prog_addr_unit i_prog_addr_unit (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .br_kind(br_kind),
    .tgt_hi(tgt_hi), .tgt_lo(tgt_lo), .cond(cond), .acc_zero(acc_zero),
    .carry(carry), .test_in(test_in), .imm_nib(imm_nib),
    .fetch_addr(fetch_addr), .ret_load(ret_load), .ret_nib(ret_nib)
  );

  function automatic bit ref_taken();
    bit t = 0;
    if (cond[2] && acc_zero) t = 1;
    if (cond[1] && carry)    t = 1;
    if (cond[0] && !test_in) t = 1;
    if (cond[3]) t = !t;
    return t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_stk = '{0, 0, 0}; m_rl = 0; m_rn = 0;
    end else begin
      int nx;
      m_rl = 0;
      case (br_kind)
        3'd1: nx = tgt_hi * 256 + tgt_lo;
        3'd2: begin
          m_stk.push_front((m_pc + 2) % 4096);
          void'(m_stk.pop_back());
          nx = tgt_hi * 256 + tgt_lo;
        end
        3'd3: begin
          nx = m_stk.pop_front();
          m_stk.push_back(m_stk[$]);
          m_rl = 1; m_rn = imm_nib;
        end
        3'd4: nx = ref_taken() ? (m_pc / 256) * 256 + tgt_lo : (m_pc + 2) % 4096;
        3'd5: nx = (m_pc / 256) * 256 + tgt_lo;
        default: nx = adv_en ? (m_pc + 1) % 4096 : m_pc;
      endcase
      m_pc = nx;
    end
    #2;
    checks++;
    if (fetch_addr !== 12'(m_pc)) begin
      failures++;
      $display("FAIL %s fetch_addr actual=%h expected=%h", cur_req, fetch_addr, m_pc);
    end
    checks++;
    if (ret_load !== m_rl || (m_rl && ret_nib !== 4'(m_rn))) begin
      failures++;
      $display("FAIL %s ret actual=%b/%h expected=%b/%h", cur_req, ret_load, ret_nib, m_rl, m_rn);
    end
  end

  task automatic req(input logic [2:0] k, input logic [3:0] hi, input logic [7:0] lo,
                     input logic adv, input logic [3:0] nib);
    br_kind = k; tgt_hi = hi; tgt_lo = lo; adv_en = adv; imm_nib = nib;
    @(negedge clk);
  endtask

  task automatic cjmp(input logic [3:0] c, input logic az, input logic cy,
                      input logic tst, input logic [7:0] lo);
    cond = c; acc_zero = az; carry = cy; test_in = tst;
    req(3'd4, 4'h0, lo, 1'b1, 4'h0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000) begin
      @(posedge clk); wd++;
    end
    failures++;
    $display("FAIL watchdog expired at req %s", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    rst_n = 1;
    @(negedge clk);
    req(3'd3, 4'h0, 8'h00, 1'b0, 4'h9);      // R1: empty return gives 0
    cur_req = "R2";
    req(3'd0, 4'h0, 8'h00, 1'b0, 4'h0);      // hold
    repeat (3) req(3'd0, 4'h0, 8'h00, 1'b1, 4'h0);
    req(3'd6, 4'h0, 8'h00, 1'b1, 4'h0);
    req(3'd7, 4'h0, 8'h00, 1'b0, 4'h0);
    cur_req = "R3";
    req(3'd1, 4'hF, 8'hFE, 1'b0, 4'h0);
    cur_req = "R2";
    repeat (3) req(3'd0, 4'h0, 8'h00, 1'b1, 4'h0); // wrap FFF->000
    cur_req = "R8";
    req(3'd1, 4'h3, 8'h40, 1'b1, 4'h0);
    req(3'd5, 4'h0, 8'h7A, 1'b1, 4'h0);
    cur_req = "R7";
    req(3'd5, 4'h0, 8'h01, 1'b0, 4'h0);
    cur_req = "R4";
    req(3'd2, 4'h1, 8'h10, 1'b1, 4'h0);
    req(3'd2, 4'h2, 8'hFF, 1'b0, 4'h0);
    req(3'd2, 4'h5, 8'h20, 1'b0, 4'h0);
    cur_req = "R9";
    req(3'd2, 4'h7, 8'h30, 1'b1, 4'h0);      // fourth push drops oldest
    cur_req = "R5";
    req(3'd3, 4'h0, 8'h00, 1'b1, 4'hA);
    req(3'd3, 4'h0, 8'h00, 1'b0, 4'h5);
    req(3'd3, 4'h0, 8'h00, 1'b0, 4'hC);
    cur_req = "R10";
    req(3'd3, 4'h0, 8'h00, 1'b0, 4'h1);
    req(3'd3, 4'h0, 8'h00, 1'b0, 4'h2);
    cur_req = "R6";
    req(3'd1, 4'h6, 8'h80, 1'b0, 4'h0);
    cjmp(4'b0000, 1, 1, 0, 8'h11);           // never taken
    cjmp(4'b1000, 0, 0, 1, 8'h22);           // always taken
    cjmp(4'b0100, 1, 0, 1, 8'h33);
    cjmp(4'b0100, 0, 1, 0, 8'h44);
    cjmp(4'b0010, 0, 1, 1, 8'h55);
    cjmp(4'b0001, 0, 0, 0, 8'h66);
    cjmp(4'b0001, 0, 0, 1, 8'h77);
    cjmp(4'b1110, 0, 1, 1, 8'h88);
    cjmp(4'b1111, 0, 0, 1, 8'h99);
    cjmp(4'b0110, 0, 0, 0, 8'hFE);
    cur_req = "R8";
    for (int i = 0; i < 400; i++) begin
      cond = 4'($urandom); acc_zero = 1'($urandom); carry = 1'($urandom);
      test_in = 1'($urandom);
      req(3'($urandom), 4'($urandom), 8'($urandom), 1'($urandom), 4'($urandom));
    end
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule